// File: doc/BRIEF.md
# Event-Timer Register Window Decoder

This block is the bus-facing slave of a multi-timer event-timer device. It decodes a 1 KB register window. It accepts one read or write request per cycle, 1, 2, 4 or 8 bytes wide, at any byte address inside the window. It answers every request exactly one cycle later.

The block holds three registers itself. The first is a read-only capability word. The second is the general configuration, which carries the enable and legacy-route bits. The third is the interrupt status, which is set by timer events and cleared by writing ones. Main-counter accesses and per-timer accesses are not stored here. The counter and timer-channel blocks present their current values on read buses. The decoder extracts the addressed bytes for reads. For writes it merges the new bytes into the current value, applies the register's writable-bit mask, and forwards the full 64-bit result with a one-cycle strobe.

Narrow accesses always act on the naturally aligned 64-bit register that contains the address. An access that is misaligned for its own length is rejected as a whole, and so is any length other than 1, 2, 4 or 8.

Top module: `evt_timer_regwin`

## Requirements
- R1: An access is legal only when the length is 1, 2, 4 or 8 and the address is a multiple of the length. An illegal read returns all 64 bits set to one.
- R2: An illegal write changes no register and raises no forwarding strobe.
- R3: A legal read returns the addressed 64-bit register shifted right by 8·(addr mod 8) bits and masked to the access length. Bytes above the length read as zero.
- R4: A legal narrow write replaces only the bytes it covers, at bit offset 8·(addr mod 8). All other bits keep their previous value.
- R5: In the general configuration register at 0x010, only bit 0 (enable) and bit 1 (legacy route) are writable. Both are 0 after reset.
- R6: A timer configuration write forwards a value in which only the bits of mask 0x3F4E take the merged write data. All other bits keep the timer's current value.
- R7: The capability register at 0x000 reads as follows: REV_ID in [7:0], NUM_TIMERS−1 in [12:8], 1 in bit 13, 0 in bit 14, 1 in bit 15, VENDOR_ID in [31:16] and PERIOD_FS in [63:32]. Writes to it have no effect.
- R8: Interrupt status at 0x020 holds one bit per timer, with bit n for timer n. An event input sets its bit on the next cycle. Writing a one to a bit clears it. When an event and a clear hit the same bit in the same cycle, the set wins. The register reads 0 after reset.
- R9: Offsets that map to no register read as 0, and writes to them have no effect. This covers the reserved words, sub-slot 0x18 of a timer, and timer slots with an index of NUM_TIMERS or more.
- R10: Every request gets rsp_valid exactly one cycle later, and no response comes without a request. A legal write to a forwarded register pulses exactly one of cnt_we or tmr_we in that response cycle.
- R11: The main counter is at 0x0F0. Timer n occupies 0x100+0x20·n, with its configuration at +0x00, its comparator at +0x08 and its message route at +0x10. A forwarded timer write reports the index n on tmr_sel, and reports the field on tmr_field as 0, 1 or 2 in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address inside the window |
| req_len | input | 4 | Access length in bytes |
| req_wdata | input | 64 | Write data, right-aligned |
| rsp_valid | output | 1 | Response one cycle after a request |
| rsp_rdata | output | 64 | Read data (0 for writes) |
| cfg_enable | output | 1 | General configuration bit 0 |
| cfg_legacy | output | 1 | General configuration bit 1 |
| irq_event | input | NUM_TIMERS | Per-timer event, sets the status bit |
| irq_status | output | NUM_TIMERS | Interrupt status bits |
| cnt_rdata | input | 64 | Current main-counter value |
| cnt_we | output | 1 | Main-counter write strobe |
| tmr_cfg_rdata | input | 64·NUM_TIMERS | Timer configurations, timer n at [64n+63:64n] |
| tmr_cmp_rdata | input | 64·NUM_TIMERS | Timer comparators, same packing |
| tmr_route_rdata | input | 64·NUM_TIMERS | Timer message routes, same packing |
| tmr_we | output | 1 | Timer register write strobe |
| tmr_sel | output | 3 | Timer index of the forwarded write |
| tmr_field | output | 2 | 0 configuration, 1 comparator, 2 route |
| fwd_data | output | 64 | Merged and masked value to store |

## Verification
The assertions assume three things about the inputs. First, requests are single-cycle pulses with stable fields while req_valid is high. Second, the neighbouring blocks hold their read buses steady during the request cycle. Third, reset is held for at least one clock edge.

The stimulus satisfies these assumptions. It drives every request for exactly one cycle, changing inputs only on the falling edge. The counter and timer read buses stay constant for the whole run. Event inputs are raised only together with a request or alone for a single cycle. This keeps every response and every status update attributable to one known cause.

// File: rtl/evt_timer_regwin.sv
module evt_timer_regwin #(
  parameter int          NUM_TIMERS = 3,
  parameter logic [7:0]  REV_ID     = 8'h01,
  parameter logic [15:0] VENDOR_ID  = 16'h1D0F,
  parameter logic [31:0] PERIOD_FS  = 32'h05F5E100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [9:0]              req_addr,
  input  logic [3:0]              req_len,
  input  logic [63:0]             req_wdata,
  output logic                    rsp_valid,
  output logic [63:0]             rsp_rdata,
  output logic                    cfg_enable,
  output logic                    cfg_legacy,
  input  logic [NUM_TIMERS-1:0]   irq_event,
  output logic [NUM_TIMERS-1:0]   irq_status,
  input  logic [63:0]             cnt_rdata,
  output logic                    cnt_we,
  input  logic [NUM_TIMERS*64-1:0] tmr_cfg_rdata,
  input  logic [NUM_TIMERS*64-1:0] tmr_cmp_rdata,
  input  logic [NUM_TIMERS*64-1:0] tmr_route_rdata,
  output logic                    tmr_we,
  output logic [2:0]              tmr_sel,
  output logic [1:0]              tmr_field,
  output logic [63:0]             fwd_data
);

  localparam logic [63:0] CFG_WMASK  = 64'h3;
  localparam logic [63:0] TCFG_WMASK = 64'h3F4E;
  localparam logic [4:0]  NT_M1      = 5'(NUM_TIMERS - 1);
  localparam logic [63:0] CAP_VALUE  = {PERIOD_FS, VENDOR_ID, 1'b1, 1'b0, 1'b1, NT_M1, REV_ID};

  logic [1:0]  cfg_q;
  logic [2:0]  amask;
  logic        len_ok, legal;
  logic [5:0]  sh;
  logic [63:0] lane, bmask, wshift, old_val, merged, wmask, fwd_val, rd_val;
  logic [6:0]  word;
  logic [2:0]  tidx;
  logic [1:0]  tfld;
  logic        hit_cap, hit_cfg, hit_isr, hit_cnt, hit_tmr;
  logic        wr_ok;
  logic [63:0] tsel_cfg, tsel_cmp, tsel_route;

  assign amask  = req_len[2:0] - 3'd1;
  assign len_ok = (req_len == 4'd1) || (req_len == 4'd2) || (req_len == 4'd4) || (req_len == 4'd8);
  assign legal  = len_ok && ((req_addr[2:0] & amask) == 3'd0);
  assign sh     = {req_addr[2:0], 3'b000};

  always_comb begin
    case (req_len)
      4'd1:    lane = 64'h0000_0000_0000_00FF;
      4'd2:    lane = 64'h0000_0000_0000_FFFF;
      4'd4:    lane = 64'h0000_0000_FFFF_FFFF;
      4'd8:    lane = '1;
      default: lane = '0;
    endcase
  end

  assign bmask  = lane << sh;
  assign wshift = req_wdata << sh;

  assign word    = req_addr[9:3];
  assign tidx    = req_addr[7:5];
  assign tfld    = req_addr[4:3];
  assign hit_cap = (word == 7'h00);
  assign hit_cfg = (word == 7'h02);
  assign hit_isr = (word == 7'h04);
  assign hit_cnt = (word == 7'h1E);
  assign hit_tmr = (req_addr[9:8] == 2'b01) && (32'(tidx) < NUM_TIMERS) && (tfld != 2'd3);

  always_comb begin
    tsel_cfg   = '0;
    tsel_cmp   = '0;
    tsel_route = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (32'(tidx) == i) begin
        tsel_cfg   = tmr_cfg_rdata[i*64 +: 64];
        tsel_cmp   = tmr_cmp_rdata[i*64 +: 64];
        tsel_route = tmr_route_rdata[i*64 +: 64];
      end
    end
  end

  always_comb begin
    old_val = '0;
    if (hit_cap)      old_val = CAP_VALUE;
    else if (hit_cfg) old_val = {62'd0, cfg_q};
    else if (hit_isr) old_val = 64'(irq_status);
    else if (hit_cnt) old_val = cnt_rdata;
    else if (hit_tmr) begin
      case (tfld)
        2'd0:    old_val = tsel_cfg;
        2'd1:    old_val = tsel_cmp;
        default: old_val = tsel_route;
      endcase
    end
  end

  assign merged  = (old_val & ~bmask) | (wshift & bmask);
  assign wmask   = (hit_tmr && tfld == 2'd0) ? TCFG_WMASK : (hit_cfg ? CFG_WMASK : '1);
  assign fwd_val = (merged & wmask) | (old_val & ~wmask);
  assign rd_val  = (old_val >> sh) & lane;
  assign wr_ok   = req_valid && req_write && legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      cfg_q      <= '0;
      irq_status <= '0;
      cnt_we     <= 1'b0;
      tmr_we     <= 1'b0;
      tmr_sel    <= '0;
      tmr_field  <= '0;
      fwd_data   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid && !req_write) rsp_rdata <= legal ? rd_val : '1;
      else                         rsp_rdata <= '0;
      if (wr_ok && hit_cfg) cfg_q <= fwd_val[1:0];
      if (wr_ok && hit_isr) irq_status <= (irq_status & ~wshift[NUM_TIMERS-1:0] & ~bmask[NUM_TIMERS-1:0])
                                          | (irq_status & ~wshift[NUM_TIMERS-1:0] &  bmask[NUM_TIMERS-1:0])
                                          | (irq_status & ~bmask[NUM_TIMERS-1:0]) | irq_event;
      else                  irq_status <= irq_status | irq_event;
      cnt_we <= wr_ok && hit_cnt;
      tmr_we <= wr_ok && hit_tmr;
      if (wr_ok) begin
        tmr_sel   <= tidx;
        tmr_field <= tfld;
        fwd_data  <= fwd_val;
      end
    end
  end

  assign cfg_enable = cfg_q[0];
  assign cfg_legacy = cfg_q[1];

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R10
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R10
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_we && tmr_we)); // R10
  AST_STROBE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_we || tmr_we) |-> $past(req_valid && req_write)); // R10
  AST_OVERSIZE_RD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_len > 4'd8) |=> (rsp_rdata == '1)); // R1
  AST_OVERSIZE_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_len > 4'd8) |=> (!cnt_we && !tmr_we && $stable(cfg_q))); // R2
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(cfg_q)); // R5
  AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_event) |=> ((irq_status & $past(irq_event)) == $past(irq_event))); // R8

endmodule

// File: tb/test_evt_timer_regwin.sv
module test_evt_timer_regwin;
  localparam int NT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [3:0]  req_len = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        cfg_enable, cfg_legacy;
  logic [NT-1:0] irq_event = '0;
  logic [NT-1:0] irq_status;
  logic [63:0] cnt_rdata = 64'h1122_3344_5566_7788;
  logic        cnt_we, tmr_we;
  logic [2:0]  tmr_sel;
  logic [1:0]  tmr_field;
  logic [63:0] fwd_data;
  logic [63:0] tcfg_m [NT];
  logic [63:0] tcmp_m [NT];
  logic [63:0] troute_m [NT];
  logic [NT*64-1:0] tcfg_flat, tcmp_flat, troute_flat;

  int checks = 0, fails = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [NT-1:0] pend_irq = '0;

  localparam logic [63:0] CAP = 64'h05F5_E100_1D0F_A201;
  localparam logic [63:0] TCFG_M = 64'h3F4E;

  always #2 clk = ~clk;

  initial begin
    for (int i = 0; i < NT; i++) begin
      tcfg_m[i]   = 64'h00F0_0000_0000_0030 + 64'(i);
      tcmp_m[i]   = {32'hC0DE_0000 + 32'(i), 32'h0000_1000 * 32'(i + 1)};
      troute_m[i] = 64'hA5A5_0000_0000_0100 + 64'(i * 16);
    end
  end

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      tcfg_flat[i*64 +: 64]   = tcfg_m[i];
      tcmp_flat[i*64 +: 64]   = tcmp_m[i];
      troute_flat[i*64 +: 64] = troute_m[i];
    end
  end

  evt_timer_regwin #(.NUM_TIMERS(NT)) i_evt_timer_regwin (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cfg_enable(cfg_enable), .cfg_legacy(cfg_legacy),
    .irq_event(irq_event), .irq_status(irq_status),
    .cnt_rdata(cnt_rdata), .cnt_we(cnt_we),
    .tmr_cfg_rdata(tcfg_flat), .tmr_cmp_rdata(tcmp_flat), .tmr_route_rdata(troute_flat),
    .tmr_we(tmr_we), .tmr_sel(tmr_sel), .tmr_field(tmr_field), .fwd_data(fwd_data)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%016h expected 0x%016h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] merge(input logic [63:0] old, input logic [9:0] a,
                                        input int len, input logic [63:0] d);
    logic [63:0] r = old;
    int off = int'(a[2:0]);
    for (int b = 0; b < 8; b++)
      if (b >= off && b < off + len) r[b*8 +: 8] = d[(b-off)*8 +: 8];
    return r;
  endfunction

  // driver: one request, expected response pushed to the scoreboard
  task automatic access(input bit wr, input logic [9:0] a, input logic [3:0] len,
                        input logic [63:0] d, input logic [63:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_len = len; req_wdata = d;
    irq_event = pend_irq;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0; irq_event = '0; pend_irq = '0;
  endtask

  // monitor: pops one expectation per response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10: response without request, actual 1 expected 0");
      end else begin
        check($sformatf("%s rsp", tag_q.pop_front()), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 reset cfg", {62'd0, cfg_legacy, cfg_enable}, 64'd0);
    check("R8 reset status", 64'(irq_status), 64'd0);
    check("R10 reset rsp_valid", 64'(rsp_valid), 64'd0);

    // R7 capability and R3 narrow extraction
    access(0, 10'h000, 4'd8, 0, CAP, "R7 cap");
    access(0, 10'h001, 4'd1, 0, 64'hA2, "R3 cap byte1");
    access(0, 10'h002, 4'd2, 0, 64'h1D0F, "R3 cap half");
    access(0, 10'h004, 4'd4, 0, 64'h05F5_E100, "R3 cap upper");
    access(1, 10'h000, 4'd8, 64'h0, 64'd0, "R7 cap write");
    access(0, 10'h000, 4'd8, 0, CAP, "R7 cap after write");

    // R1 illegal reads
    access(0, 10'h002, 4'd4, 0, '1, "R1 misaligned");
    access(0, 10'h000, 4'd3, 0, '1, "R1 len3");
    access(0, 10'h000, 4'd9, 0, '1, "R1 len9");

    // R5 configuration
    access(1, 10'h010, 4'd8, '1, 64'd0, "R5 cfg wr");
    check("R5 cfg bits", {62'd0, cfg_legacy, cfg_enable}, 64'd3);
    access(0, 10'h010, 4'd8, 0, 64'd3, "R5 cfg rd");
    access(1, 10'h011, 4'd2, 64'h0, 64'd0, "R2 illegal cfg wr");
    access(0, 10'h010, 4'd8, 0, 64'd3, "R2 cfg unchanged");
    access(1, 10'h011, 4'd1, 64'h00, 64'd0, "R4 cfg upper byte");
    access(0, 10'h010, 4'd8, 0, 64'd3, "R4 cfg kept");
    access(1, 10'h010, 4'd1, 64'hFE, 64'd0, "R5 cfg byte0");
    check("R5 enable cleared", {62'd0, cfg_legacy, cfg_enable}, 64'd2);

    // R8 interrupt status
    pend_irq = 3'b010;
    access(0, 10'h020, 4'd8, 0, 64'd0, "R8 rd before set");
    check("R8 set", 64'(irq_status), 64'd2);
    access(0, 10'h020, 4'd8, 0, 64'd2, "R8 rd status");
    access(1, 10'h020, 4'd1, 64'h00, 64'd0, "R8 write zero");
    check("R8 zero keeps", 64'(irq_status), 64'd2);
    access(1, 10'h020, 4'd1, 64'h02, 64'd0, "R8 w1c");
    check("R8 cleared", 64'(irq_status), 64'd0);
    pend_irq = 3'b001;
    access(0, 10'h020, 4'd8, 0, 64'd0, "R8 set bit0");
    pend_irq = 3'b001;
    access(1, 10'h020, 4'd1, 64'h01, 64'd0, "R8 set vs clear");
    check("R8 set wins", 64'(irq_status), 64'd1);

    // counter forwarding
    access(0, 10'h0F4, 4'd4, 0, 64'h1122_3344, "R3 cnt upper");
    access(1, 10'h0F2, 4'd2, 64'hABCD, 64'd0, "R4 cnt narrow wr");
    check("R10 cnt_we", {62'd0, cnt_we, tmr_we}, 64'd2);
    check("R4 cnt merge", fwd_data, merge(cnt_rdata, 10'h0F2, 2, 64'hABCD));
    access(1, 10'h0F1, 4'd2, 64'h1, 64'd0, "R2 cnt misaligned");
    check("R2 no strobe", {62'd0, cnt_we, tmr_we}, 64'd0);

    // timer channels
    access(1, 10'h140, 4'd8, '1, 64'd0, "R6 tcfg wr");
    check("R11 tmr strobe", {59'd0, tmr_we, tmr_sel, cnt_we}, {59'd0, 1'b1, 3'd2, 1'b0});
    check("R11 tmr field", 64'(tmr_field), 64'd0);
    check("R6 tcfg mask", fwd_data, (64'hFFFF_FFFF_FFFF_FFFF & TCFG_M) | (tcfg_m[2] & ~TCFG_M));
    access(1, 10'h141, 4'd1, 64'h00, 64'd0, "R6 tcfg byte");
    check("R6 tcfg byte val", fwd_data,
          (merge(tcfg_m[2], 10'h141, 1, 64'h0) & TCFG_M) | (tcfg_m[2] & ~TCFG_M));
    access(0, 10'h128, 4'd8, 0, tcmp_m[1], "R11 cmp1 rd");
    access(0, 10'h100, 4'd8, 0, tcfg_m[0], "R11 cfg0 rd");
    access(1, 10'h10C, 4'd4, 64'h1234_5678, 64'd0, "R4 cmp0 wr");
    check("R11 cmp0 sel", {60'd0, tmr_sel, tmr_we}, {60'd0, 3'd0, 1'b1});
    check("R11 cmp0 field", 64'(tmr_field), 64'd1);
    check("R4 cmp0 merge", fwd_data, merge(tcmp_m[0], 10'h10C, 4, 64'h1234_5678));
    access(0, 10'h130, 4'd8, 0, troute_m[1], "R11 route1 rd");
    access(1, 10'h110, 4'd8, 64'hDEAD_BEEF_0000_0001, 64'd0, "R11 route0 wr");
    check("R11 route field", 64'(tmr_field), 64'd2);
    check("R11 route data", fwd_data, 64'hDEAD_BEEF_0000_0001);

    // R9 unmapped offsets
    access(0, 10'h160, 4'd8, 0, 64'd0, "R9 timer3 rd");
    access(1, 10'h160, 4'd8, '1, 64'd0, "R9 timer3 wr");
    check("R9 timer3 no strobe", {62'd0, cnt_we, tmr_we}, 64'd0);
    access(0, 10'h118, 4'd8, 0, 64'd0, "R9 slot3 rd");
    access(1, 10'h118, 4'd8, '1, 64'd0, "R9 slot3 wr");
    check("R9 slot3 no strobe", {62'd0, cnt_we, tmr_we}, 64'd0);
    access(1, 10'h008, 4'd8, '1, 64'd0, "R9 rsvd wr");
    access(0, 10'h008, 4'd8, 0, 64'd0, "R9 rsvd rd");
    access(0, 10'h3F8, 4'd8, 0, 64'd0, "R9 top rd");
    access(0, 10'h010, 4'd8, 0, 64'd2, "R9 cfg untouched");

    repeat (3) @(negedge clk);
    check("R10 queue drained", 64'(exp_q.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule